// File: doc/BRIEF.md
# Arm Source Qualifier with Programmable Delay

This block sits in front of an acquisition engine and turns several arm candidates into one arm event. The candidates are a software request, two front-panel pins, the flag of an input-level comparator, and one TTL and one ECL backplane trigger line. Each candidate is asynchronous to the sample reference clock. Each one is first synchronised through a two-flop chain, and only then is its rising edge detected. A configuration picks one primary source. It can also pick the OR of the primary source and a secondary one.

A qualified event loads a delay counter that runs on the reference clock. When the count expires, the block emits a single-cycle arm pulse. This pulse feeds the engine, and it can also be driven off the block to synchronise other instruments. After each pulse there is a fixed holdoff before the next event is accepted, which keeps the arm rate within the supported re-arm rate.

Events that arrive while a delay or a holdoff is in progress are discarded, and a sticky overrun flag records them. A ready output tells upstream logic when an arm would be accepted. With re-arm disabled, the block stops after one arm and waits until re-arm is enabled again.

Top module: `arm_qualifier`

## Requirements
- R1: After reset, arm_o and overrun_o are low, and ready_o equals engine_ready_i.
- R2: With or_en_i low, a rising edge on arm_raw_i[sel_a_i] produces an arm pulse, and edges on any other source are ignored. Source bit positions: 0 software, 1 front pin A, 2 front pin B, 3 level comparator, 4 TTL line, 5 ECL line.
- R3: With or_en_i high, a rising edge on either arm_raw_i[sel_a_i] or arm_raw_i[sel_b_i] produces an arm pulse.
- R4: A select code of 6 or 7 selects no source, so no arm results from it.
- R5: When arm_raw_i rises and the first clk_i rising edge that samples it high is edge 1, arm_o is high in the cycle after edge delay_i+3. A delay_i of 0 behaves as 1.
- R6: arm_o is high for exactly one cycle per accepted event. A source held high yields only one arm.
- R7: ready_o returns high REARM_CYC-1 cycles after the cycle in which arm_o is high, and is low in between. Two arm pulses are never closer than REARM_CYC cycles.
- R8: An edge on a selected source that arrives while a delay is counting or during the holdoff is ignored. It sets overrun_o, which stays high until reset.
- R9: While engine_ready_i is low, ready_o is low and selected edges are ignored without setting overrun_o.
- R10: With rearm_en_i low, after an arm the block stays not ready and ignores edges. Raising rearm_en_i makes ready_o high after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| arm_raw_i | input | 6 | Raw asynchronous arm candidates |
| sel_a_i | input | 3 | Primary source select |
| sel_b_i | input | 3 | Secondary source select, used when or_en_i is high |
| or_en_i | input | 1 | Arm on the OR of the primary and secondary sources |
| delay_i | input | 20 | Arm delay in reference cycles, sampled when an event is accepted |
| rearm_en_i | input | 1 | Return to ready after the holdoff |
| engine_ready_i | input | 1 | Downstream engine can take an arm |
| arm_o | output | 1 | Single-cycle qualified arm pulse |
| ready_o | output | 1 | Block is idle and the engine is ready |
| overrun_o | output | 1 | Sticky flag for discarded events |

## Verification
The hardest case to reach from the ports is an event that lands inside a running delay. To get there, the bench must produce a second clean rising edge on the same source while the counter is still counting, and must then show that the first pulse still arrives on time and no second pulse follows. The bench programs a long delay of 20 cycles. It drops the source and raises it again a few cycles after the first edge, so the re-synchronised second edge falls well inside the count window. It then checks the pulse timing, the pulse count and the sticky flag. The single-shot stop is reached by clearing re-arm before an arm and then firing again once the holdoff has ended.

// File: rtl/arm_qual_pkg.sv
package arm_qual_pkg;
  localparam int unsigned NUM_SRC = 6;
  localparam int unsigned SEL_W   = 3;

  typedef enum logic [2:0] {
    SRC_SOFT  = 3'd0,
    SRC_PIN_A = 3'd1,
    SRC_PIN_B = 3'd2,
    SRC_LEVEL = 3'd3,
    SRC_TTL   = 3'd4,
    SRC_ECL   = 3'd5
  } arm_src_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_HOLD  = 2'd2,
    ST_DONE  = 2'd3
  } arm_state_e;
endpackage

// File: rtl/arm_sync_edge.sv
module arm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  assert_single_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/arm_src_mux.sv
module arm_src_mux
  import arm_qual_pkg::*;
(
  input  logic [NUM_SRC-1:0] rise_i,
  input  logic [SEL_W-1:0]   sel_a_i,
  input  logic [SEL_W-1:0]   sel_b_i,
  input  logic               or_en_i,
  output logic               event_o
);
  logic [NUM_SRC-1:0] mask_a, mask_b;

  // codes at or above NUM_SRC decode to nothing
  always_comb begin
    mask_a = '0;
    mask_b = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_a_i == SEL_W'(i)) mask_a[i] = 1'b1;
      if (sel_b_i == SEL_W'(i)) mask_b[i] = 1'b1;
    end
  end

  assign event_o = (|(rise_i & mask_a)) | (or_en_i & (|(rise_i & mask_b)));
endmodule

// File: rtl/arm_delay_timer.sv
module arm_delay_timer
  import arm_qual_pkg::*;
#(
  parameter int unsigned DLY_W     = 20,
  parameter int unsigned REARM_CYC = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             event_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             rearm_en_i,
  input  logic             engine_ready_i,
  output logic             arm_o,
  output logic             ready_o,
  output logic             overrun_o
);
  localparam int unsigned GAP_W  = $clog2(REARM_CYC + 1);
  localparam logic [GAP_W-1:0] GAP_LD = GAP_W'(REARM_CYC - 1);

  arm_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [GAP_W-1:0] gap_q;
  logic             arm_q, ovr_q;
  logic             busy;

  assign busy = (state_q == ST_COUNT) || (state_q == ST_HOLD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      gap_q   <= '0;
      arm_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      arm_q <= 1'b0;
      if (event_i && busy) ovr_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (event_i && engine_ready_i) begin
          cnt_q   <= (delay_i == '0) ? DLY_W'(1) : delay_i;
          state_q <= ST_COUNT;
        end
        ST_COUNT: if (cnt_q == DLY_W'(1)) begin
          arm_q   <= 1'b1;
          gap_q   <= GAP_LD;
          state_q <= ST_HOLD;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ST_HOLD: if (gap_q == GAP_W'(1)) begin
          state_q <= rearm_en_i ? ST_IDLE : ST_DONE;
        end else begin
          gap_q <= gap_q - 1'b1;
        end
        ST_DONE: if (rearm_en_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign arm_o     = arm_q;
  assign overrun_o = ovr_q;
  assign ready_o   = (state_q == ST_IDLE) && engine_ready_i;

  // independent spacing monitor
  logic [GAP_W-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_q <= GAP_W'(REARM_CYC);
    else if (arm_q)                       since_q <= GAP_W'(1);
    else if (since_q < GAP_W'(REARM_CYC)) since_q <= since_q + 1'b1;
  end

  assert_arm_spacing_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |-> since_q == GAP_W'(REARM_CYC));
  assert_arm_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_q |=> !arm_q);
  assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_q |=> ovr_q);
  assert_count_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_COUNT) |-> (cnt_q != '0));
  assert_ready_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !arm_q);
  assert_no_ready_when_engine_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !engine_ready_i |-> !ready_o);
endmodule

// File: rtl/arm_qualifier.sv
module arm_qualifier
  import arm_qual_pkg::*;
#(
  parameter int unsigned DLY_W       = 20,
  parameter int unsigned REARM_CYC   = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] arm_raw_i,
  input  logic [SEL_W-1:0]   sel_a_i,
  input  logic [SEL_W-1:0]   sel_b_i,
  input  logic               or_en_i,
  input  logic [DLY_W-1:0]   delay_i,
  input  logic               rearm_en_i,
  input  logic               engine_ready_i,
  output logic               arm_o,
  output logic               ready_o,
  output logic               overrun_o
);
  logic [NUM_SRC-1:0] rise;
  logic               sel_event;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    arm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (arm_raw_i[g]),
      .rise_o (rise[g])
    );
  end

  arm_src_mux u_mux (
    .rise_i  (rise),
    .sel_a_i (sel_a_i),
    .sel_b_i (sel_b_i),
    .or_en_i (or_en_i),
    .event_o (sel_event)
  );

  arm_delay_timer #(.DLY_W(DLY_W), .REARM_CYC(REARM_CYC)) u_timer (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .event_i        (sel_event),
    .delay_i        (delay_i),
    .rearm_en_i     (rearm_en_i),
    .engine_ready_i (engine_ready_i),
    .arm_o          (arm_o),
    .ready_o        (ready_o),
    .overrun_o      (overrun_o)
  );

  assert_event_has_edge_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_event |-> (rise != '0));
  assert_no_sel_no_event_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_a_i >= SEL_W'(NUM_SRC) && (!or_en_i || sel_b_i >= SEL_W'(NUM_SRC))) |-> !sel_event);
endmodule

// File: tb/tb_arm_qualifier.sv
module tb_arm_qualifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  arm_raw_i = '0;
  logic [2:0]  sel_a_i = '0, sel_b_i = '0;
  logic        or_en_i = 1'b0;
  logic [19:0] delay_i = 20'd1;
  logic        rearm_en_i = 1'b1;
  logic        engine_ready_i = 1'b1;
  logic        arm_o, ready_o, overrun_o;

  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  arm_qualifier dut (
    .clk_i, .rst_ni, .arm_raw_i, .sel_a_i, .sel_b_i, .or_en_i,
    .delay_i, .rearm_en_i, .engine_ready_i, .arm_o, .ready_o, .overrun_o
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  // fire source src at a negedge; report first arm cycle, pulse count, ready return cycle
  task automatic run_arm(input int src, input bit hold, input int cyc_max,
                         output int first_k, output int npulse, output int ready_k);
    first_k = 0; npulse = 0; ready_k = 0;
    arm_raw_i[src] = 1'b1;
    for (int k = 1; k <= cyc_max; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (k == 4 && !hold) arm_raw_i[src] = 1'b0;
      if (arm_o) begin
        if (first_k == 0) first_k = k;
        npulse++;
      end else if (first_k != 0 && ready_k == 0 && ready_o) ready_k = k;
    end
    arm_raw_i[src] = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check(arm_o == 1'b0, "R1 arm_o", arm_o, 0);
    check(overrun_o == 1'b0, "R1 overrun_o", overrun_o, 0);
    check(ready_o == engine_ready_i, "R1 ready_o", ready_o, engine_ready_i);
  endtask

  task automatic t_single_sources;
    int f, n, r;
    delay_i = 20'd1; or_en_i = 1'b0;
    for (int s = 0; s < 6; s++) begin
      sel_a_i = 3'(s);
      run_arm(s, 1'b0, 20, f, n, r);
      check(f == 4, "R2 source arms", f, 4);
      idle(4);
    end
    sel_a_i = 3'd2; // R2: other source ignored
    run_arm(4, 1'b0, 25, f, n, r);
    check(n == 0, "R2 unselected ignored", n, 0);
  endtask

  task automatic t_no_source;
    int f, n, r;
    sel_a_i = 3'd6; or_en_i = 1'b0;
    for (int s = 0; s < 6; s++) begin
      run_arm(s, 1'b0, 12, f, n, r);
      check(n == 0, "R4 code 6 no arm", n, 0);
    end
    sel_a_i = 3'd7; sel_b_i = 3'd7; or_en_i = 1'b1;
    run_arm(0, 1'b0, 12, f, n, r);
    check(n == 0, "R4 code 7 no arm", n, 0);
  endtask

  task automatic t_or_mode;
    int f, n, r;
    sel_a_i = 3'd1; sel_b_i = 3'd5; or_en_i = 1'b1;
    run_arm(5, 1'b0, 20, f, n, r);
    check(f == 4, "R3 secondary arms", f, 4);
    idle(4);
    run_arm(1, 1'b0, 20, f, n, r);
    check(f == 4, "R3 primary arms", f, 4);
    idle(4);
    run_arm(3, 1'b0, 20, f, n, r);
    check(n == 0, "R3 third source ignored", n, 0);
    or_en_i = 1'b0;
    run_arm(5, 1'b0, 20, f, n, r);
    check(n == 0, "R3 secondary off without OR", n, 0);
  endtask

  task automatic t_delay;
    int f, n, r;
    sel_a_i = 3'd0; or_en_i = 1'b0;
    delay_i = 20'd0;
    run_arm(0, 1'b0, 30, f, n, r);
    check(f == 4, "R5 delay 0 clamps to 1", f, 4);
    idle(4);
    delay_i = 20'd7;
    run_arm(0, 1'b0, 30, f, n, r);
    check(f == 10, "R5 delay 7", f, 10);
    idle(4);
    delay_i = 20'd15;
    run_arm(3, 1'b0, 40, f, n, r);
    check(n == 0, "R5 other source idle", n, 0);
    run_arm(0, 1'b0, 40, f, n, r);
    check(f == 18, "R5 delay 15", f, 18);
    delay_i = 20'd1;
    idle(4);
  endtask

  task automatic t_pulse;
    int f, n, r;
    sel_a_i = 3'd3;
    run_arm(3, 1'b1, 40, f, n, r);
    check(n == 1, "R6 held level one pulse", n, 1);
    idle(4);
  endtask

  task automatic t_rearm;
    int f, n, r;
    sel_a_i = 3'd2; delay_i = 20'd1;
    run_arm(2, 1'b0, 30, f, n, r);
    check(r - f == 9, "R7 ready return gap", r - f, 9);
    idle(2);
  endtask

  task automatic t_engine_busy;
    int f, n, r;
    sel_a_i = 3'd0;
    engine_ready_i = 1'b0;
    @(negedge clk_i);
    check(ready_o == 1'b0, "R9 ready low", ready_o, 0);
    run_arm(0, 1'b0, 20, f, n, r);
    check(n == 0, "R9 edge ignored", n, 0);
    check(overrun_o == 1'b0, "R9 no overrun", overrun_o, 0);
    engine_ready_i = 1'b1;
    @(negedge clk_i);
    check(ready_o == 1'b1, "R9 ready back", ready_o, 1);
  endtask

  task automatic t_single_shot;
    int f, n, r;
    sel_a_i = 3'd4; rearm_en_i = 1'b0;
    run_arm(4, 1'b0, 20, f, n, r);
    check(f == 4, "R10 first arm", f, 4);
    idle(12);
    check(ready_o == 1'b0, "R10 stays not ready", ready_o, 0);
    run_arm(4, 1'b0, 20, f, n, r);
    check(n == 0, "R10 edge ignored when stopped", n, 0);
    check(overrun_o == 1'b0, "R10 no overrun when stopped", overrun_o, 0);
    rearm_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    check(ready_o == 1'b1, "R10 ready after rearm", ready_o, 1);
  endtask

  task automatic t_overrun;
    int f, n;
    f = 0; n = 0;
    sel_a_i = 3'd1; delay_i = 20'd20;
    check(overrun_o == 1'b0, "R8 overrun clear before", overrun_o, 0);
    arm_raw_i[1] = 1'b1;
    for (int k = 1; k <= 45; k++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (k == 4) arm_raw_i[1] = 1'b0;
      if (k == 6) arm_raw_i[1] = 1'b1;
      if (k == 9) arm_raw_i[1] = 1'b0;
      if (arm_o) begin
        if (f == 0) f = k;
        n++;
      end
    end
    check(f == 23, "R8 first arm on time", f, 23);
    check(n == 1, "R8 second edge dropped", n, 1);
    check(overrun_o == 1'b1, "R8 overrun set", overrun_o, 1);
    idle(20);
    check(overrun_o == 1'b1, "R8 overrun sticky", overrun_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_single_sources();
    t_no_source();
    t_or_mode();
    t_delay();
    t_pulse();
    t_rearm();
    t_engine_busy();
    t_single_shot();
    t_overrun();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule